// File: doc/BRIEF.md
# Critical-word-first cache line burst sequencer

The block sits between a cache controller and a 64-bit data bus. It turns one start request into a burst of four double-word (8-byte) beats that move one 32-byte cache line. Reads begin at the critical double word, which the requester names through the address. The beats then wrap around the end of the line. Writes always run from double word zero upward. The block never leaves the line named at the start, so no burst crosses an aligned 32-byte boundary.

Along with the beat sequence, the block produces the write-through (WT) and cache-inhibit (CI) attributes of the transaction. These come from a transaction-kind code and the W/I/M page attribute bits. Both are latched when the burst is accepted and are held until it completes. The bus paces the burst with an acknowledge input, one beat per acknowledged cycle.

Top module: `line_burst_seq`

## Requirements
- R1: A start request accepted while idle produces exactly four beats. `beat_valid_o` and `busy_o` rise in the cycle after the start and fall in the cycle after the fourth beat is acknowledged.
- R2: For a read (`is_write_i`=0), the first beat index is `line_addr_i[4:3]`. Each later beat adds one modulo 4, so a start of 1, 2 or 3 wraps from 3 back to 0.
- R3: For a write (`is_write_i`=1), the beat indices are always 0, 1, 2, 3 in that order, whatever the low address bits are.
- R4: `burst_addr_o` carries `line_addr_i[31:5]` in its upper bits and the starting double-word index in bits [4:3]. Bits [2:0] are zero. The whole address stays fixed for the burst.
- R5: When `ack_i` is low during a burst, the beat index, `beat_valid_o` and `last_o` keep their values into the next cycle.
- R6: `last_o` is high exactly while the fourth beat is presented, and at no other time.
- R7: WT rules, by `kind_i` code:
  - 0 (instruction fetch) gives 0.
  - 1 (data read) gives 1.
  - 2 (store) gives the W bit, which is `wim_i[2]`.
  - 3 (flush/clean writeback) gives 1.
  - 4 (snoop push) gives 1.
  - 5 (external control in) gives 1.
  - 6 (external control out) gives 0.
  - 7 gives the W bit.
- R8: CI equals the I bit (`wim_i[1]`), except that it is forced to 1 for kind codes 5 and 6.
- R9: `wt_o` and `ci_o` are latched when a start is accepted and stay stable until the burst ends.
- R10: A start request that arrives while `busy_o` is high is ignored. The running sequence, its address and its attributes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request for a line burst |
| line_addr_i | input | 32 | Byte address; bits [4:3] name the critical double word |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| kind_i | input | 3 | Transaction-kind code (see R7) |
| wim_i | input | 3 | Page attributes: [2]=W, [1]=I, [0]=M |
| ack_i | input | 1 | Bus accepts the current beat |
| busy_o | output | 1 | A burst is in progress |
| beat_valid_o | output | 1 | A beat is presented |
| beat_dw_o | output | 2 | Double-word index of the current beat |
| last_o | output | 1 | Current beat is the fourth |
| burst_addr_o | output | 32 | Burst address, low three bits zero |
| wt_o | output | 1 | Write-through attribute for the transaction |
| ci_o | output | 1 | Cache-inhibit attribute for the transaction |

## Verification
The hardest case to reach from the ports is a start request that lands in the same cycle as the fourth acknowledged beat. A second hard case is a long run of stalls just before the last beat, which must leave the index and the last flag untouched.

The stimulus holds `ack_i` low at random in about a third of the cycles. It raises a spurious start, with different address, kind and attributes, in about half of the busy cycles. Over hundreds of bursts this lands starts on every beat position, including the final one. Directed bursts cover each read start position, a write with nonzero low address bits, and the forced-attribute kinds.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    K_IFETCH = 3'd0,
    K_DREAD  = 3'd1,
    K_STORE  = 3'd2,
    K_CLEAN  = 3'd3,
    K_PUSH   = 3'd4,
    K_XIN    = 3'd5,
    K_XOUT   = 3'd6,
    K_RSVD   = 3'd7
  } kind_e;

  typedef struct packed {
    logic w;
    logic i;
    logic m;
  } wim_t;
endpackage

// File: rtl/lbs_attr_decode.sv
module lbs_attr_decode
  import lbs_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       w_i,
  input  logic       i_i,
  output logic       wt_o,
  output logic       ci_o
);
  kind_e kind;
  assign kind = kind_e'(kind_i);

  always_comb begin
    unique case (kind)
      K_IFETCH: wt_o = 1'b0;
      K_DREAD:  wt_o = 1'b1;
      K_CLEAN:  wt_o = 1'b1;
      K_PUSH:   wt_o = 1'b1;
      K_XIN:    wt_o = 1'b1;
      K_XOUT:   wt_o = 1'b0;
      default:  wt_o = w_i;
    endcase
  end

  // external control accesses are always uncached
  assign ci_o = (kind == K_XIN) || (kind == K_XOUT) || i_i;
endmodule

// File: rtl/lbs_beat_seq.sv
module lbs_beat_seq #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             ack_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1);

  logic             valid_q;
  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (!valid_q) begin
      if (load_i) begin
        valid_q <= 1'b1;
        base_q  <= start_idx_i;
        cnt_q   <= '0;
      end
    end else if (ack_i) begin
      if (cnt_q == LAST_CNT) valid_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  // modulo-line wrap falls out of the IDX_W-bit add
  assign idx_o   = base_q + cnt_q;
  assign valid_o = valid_q;
  assign last_o  = valid_q && (cnt_q == LAST_CNT);
endmodule

// File: rtl/line_burst_seq.sv
module line_burst_seq #(
  parameter int ADDR_W   = 32,
  parameter int BEATS    = 4,
  parameter int DW_BYTES = 8,
  localparam int IDX_W   = $clog2(BEATS),
  localparam int OFS_W   = $clog2(DW_BYTES),
  localparam int LINE_W  = OFS_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              is_write_i,
  input  logic [2:0]        kind_i,
  input  logic [2:0]        wim_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_dw_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic              wt_o,
  output logic              ci_o
);
  import lbs_pkg::*;

  wim_t             wim;
  logic             accept;
  logic [IDX_W-1:0] start_dw;
  logic             wt_d, ci_d;
  logic             wt_q, ci_q;
  logic [ADDR_W-LINE_W-1:0] line_q;
  logic [IDX_W-1:0] sdw_q;
  logic             unused_ok;

  assign wim       = wim_t'(wim_i);
  assign unused_ok = ^{wim.m, line_addr_i[OFS_W-1:0]};
  assign accept    = start_i && !beat_valid_o;
  assign start_dw  = is_write_i ? '0 : line_addr_i[LINE_W-1:OFS_W];

  lbs_attr_decode u_attr (
    .kind_i (kind_i),
    .w_i    (wim.w),
    .i_i    (wim.i),
    .wt_o   (wt_d),
    .ci_o   (ci_d)
  );

  lbs_beat_seq #(.BEATS(BEATS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .start_idx_i (start_dw),
    .ack_i       (ack_i),
    .valid_o     (beat_valid_o),
    .idx_o       (beat_dw_o),
    .last_o      (last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_q   <= 1'b0;
      ci_q   <= 1'b0;
      line_q <= '0;
      sdw_q  <= '0;
    end else if (accept) begin
      wt_q   <= wt_d;
      ci_q   <= ci_d;
      line_q <= line_addr_i[ADDR_W-1:LINE_W];
      sdw_q  <= start_dw;
    end
  end

  assign busy_o       = beat_valid_o;
  assign wt_o         = wt_q;
  assign ci_o         = ci_q;
  assign burst_addr_o = {line_q, sdw_q, {OFS_W{1'b0}}};
endmodule

// File: rtl/lbs_chk.sv
module lbs_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ack_i,
  input logic              busy_o,
  input logic              beat_valid_o,
  input logic [IDX_W-1:0]  beat_dw_o,
  input logic              last_o,
  input logic [ADDR_W-1:0] burst_addr_o,
  input logic              wt_o,
  input logic              ci_o
);
  localparam logic [IDX_W-1:0] FINAL = '1;
  logic [IDX_W-1:0] acked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acked_q <= '0;
    else if (!beat_valid_o) acked_q <= '0;
    else if (ack_i) acked_q <= acked_q + 1'b1;
  end

  a_r1_four_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && ack_i && last_o) |-> (acked_q == FINAL));

  a_r1_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && ack_i && last_o) |=> (!beat_valid_o && !busy_o));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && ack_i && !last_o) |=> (beat_dw_o == $past(beat_dw_o) + 1'b1));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !ack_i) |=> (beat_valid_o && $stable(beat_dw_o) && $stable(last_o)));

  a_r6_last_fourth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && ack_i && !last_o) |-> (acked_q != FINAL));

  a_r9_attr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !(ack_i && last_o)) |=> ($stable(wt_o) && $stable(ci_o)));

  a_r10_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !(ack_i && last_o)) |=> ($stable(burst_addr_o) && busy_o));
endmodule

bind line_burst_seq lbs_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ack_i        (ack_i),
  .busy_o       (busy_o),
  .beat_valid_o (beat_valid_o),
  .beat_dw_o    (beat_dw_o),
  .last_o       (last_o),
  .burst_addr_o (burst_addr_o),
  .wt_o         (wt_o),
  .ci_o         (ci_o)
);

// File: tb/sim_line_burst_seq.sv
module sim_line_burst_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] line_addr_i = '0;
  logic        is_write_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [2:0]  wim_i = '0;
  logic        ack_i = 1'b0;
  logic        busy_o, beat_valid_o, last_o, wt_o, ci_o;
  logic [1:0]  beat_dw_o;
  logic [31:0] burst_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  line_burst_seq u0 (.*);

  function automatic logic [1:0] exp_dw(bit wr, logic [31:0] a, int b);
    return wr ? 2'(b) : 2'(a[4:3] + 2'(b));
  endfunction

  function automatic logic exp_wt(logic [2:0] k, logic [2:0] w);
    case (k)
      3'd0: return 1'b0;
      3'd1, 3'd3, 3'd4, 3'd5: return 1'b1;
      3'd6: return 1'b0;
      default: return w[2];
    endcase
  endfunction

  function automatic logic exp_ci(logic [2:0] k, logic [2:0] w);
    return (k == 3'd5 || k == 3'd6) ? 1'b1 : w[1];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_burst(logic [31:0] a, bit wr, logic [2:0] k, logic [2:0] w, bit noisy);
    logic [31:0] eaddr;
    logic ewt, eci;
    int beat;
    eaddr = {a[31:5], (wr ? 2'b00 : a[4:3]), 3'b000};
    ewt = exp_wt(k, w);
    eci = exp_ci(k, w);
    @(negedge clk_i);
    start_i = 1'b1; line_addr_i = a; is_write_i = wr; kind_i = k; wim_i = w; ack_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    beat = 0;
    while (beat < 4) begin
      bit a_now;
      chk("R1 busy", busy_o, 1);
      chk("R1 valid", beat_valid_o, 1);
      chk(wr ? "R3 write order" : "R2 read order", beat_dw_o, exp_dw(wr, a, beat));
      chk("R6 last", last_o, beat == 3);
      chk("R4 addr", burst_addr_o, eaddr);
      chk("R7 wt / R9", wt_o, ewt);
      chk("R8 ci / R9", ci_o, eci);
      a_now = ($urandom % 3) != 0;
      ack_i = a_now;
      if (noisy && ($urandom % 2 == 0)) begin
        // R10: spurious start with different fields
        start_i = 1'b1;
        line_addr_i = ~a;
        is_write_i = ~wr;
        kind_i = 3'($urandom % 7);
        wim_i = ~w;
      end else start_i = 1'b0;
      @(negedge clk_i);
      start_i = 1'b0;
      if (a_now) beat++;
      else chk("R5 stall hold", beat_dw_o, exp_dw(wr, a, beat));
    end
    ack_i = 1'b0;
    chk("R1 idle valid", beat_valid_o, 0);
    chk("R1 idle busy", busy_o, 0);
    chk("R6 idle last", last_o, 0);
  endtask

  initial begin
    void'($urandom(32'h51c3));
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", beat_valid_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R6 reset last", last_o, 0);
    rst_ni = 1'b1;
    // directed: every read start position, R2 wrap
    for (int s = 0; s < 4; s++)
      run_burst({24'hA5C3E1, 3'b010, 2'(s), 3'b101}, 1'b0, 3'd1, 3'b000, 1'b0);
    // R3: write with nonzero low bits starts at 0
    run_burst(32'h1234_567F, 1'b1, 3'd2, 3'b100, 1'b0);
    // R7 instruction fetch WT=0
    run_burst(32'h0000_0010, 1'b0, 3'd0, 3'b100, 1'b1);
    // R8 external control out forces CI, WT=0
    run_burst(32'hFFFF_FFF8, 1'b1, 3'd6, 3'b101, 1'b1);
    // R8 external control in forces CI
    run_burst(32'h8000_0008, 1'b0, 3'd5, 3'b000, 1'b1);
    // R7 store follows W bit
    run_burst(32'h4000_0000, 1'b1, 3'd2, 3'b000, 1'b1);
    for (int n = 0; n < 400; n++)
      run_burst($urandom, 1'($urandom), 3'($urandom % 8), 3'($urandom), 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule